// File: doc/BRIEF.md
# Timer Control Register with Software Reset

This block holds the main configuration word of a timer peripheral, written and read over a simple single-cycle register bus. The word carries the counter width, the prescaler divider, the counter/prescaler reload policy, standby and clock-on-demand controls, an auto-lock flag, a one-shot request flag and the per-channel capture settings. It also carries an enable bit and a write-only software-reset bit. A second bus location holds a debug-control value that a software reset leaves alone.

Most configuration fields are protected by the enable state. They are accepted only while the peripheral is disabled and no enable change is still in flight. Changes to the enable bit cross into the counter clock domain, which is modelled as a fixed latency. A busy flag covers the crossing. A software reset clears the configuration at once and raises its own busy flag. While that flag is set the bus is shut out. The outputs are decoded configuration signals and the two busy flags.

Top module: `timer_ctrl_reg`

## Requirements
- R1: A control write (address 0) with bit 0 set, accepted while `rst_busy` is low, clears every control field and the enable bit at that clock edge and discards all other bits of that write. `rst_busy` is then high for exactly SYNC_LAT cycles, and `en_active` is 0 once it falls.
- R2: The debug register (address 1, bit 0) keeps its value across a software reset.
- R3: Writing 0 to bit 0 starts no reset. Bit 0 always reads back as 0.
- R4: While `rst_busy` is high, every bus write is ignored (including further reset writes) and every read returns 0.
- R5: A control write that changes the enable bit (bit 1) raises `en_busy` for exactly SYNC_LAT cycles. `en_active` takes the new value on the edge where `en_busy` falls. A write that leaves bit 1 unchanged does not raise `en_busy`.
- R6: A control write made while `en_busy` is high leaves the enable bit unchanged.
- R7: Bits 20:2 are written only when the stored enable bit is 0 and `en_busy` is low, judged before the write. Otherwise they are silently dropped. The enable bit itself is not protected.
- R8: The width field, bits 3:2, decodes 0 to `cnt_16b`, 1 to `cnt_8b`, 2 to `cnt_32b`, and 3 (reserved) to none of them.
- R9: The divider field, bits 6:4, drives `div_log2` with the values 0, 1, 2, 3, 4, 6, 8 and 10 for codes 0 to 7.
- R10: `on_demand` follows bit 10. It is forced to 0 while `standby` is high and the run-in-standby bit (bit 9) is 0.
- R11: After the hardware reset, all registers, outputs and busy flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Word address (0 control, 1 debug) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| standby | input | 1 | System standby indication |
| en_active | output | 1 | Enable as seen by the counter domain |
| en_busy | output | 1 | Enable change in flight |
| rst_busy | output | 1 | Software reset in progress |
| cnt_8b | output | 1 | 8-bit counter selected |
| cnt_16b | output | 1 | 16-bit counter selected |
| cnt_32b | output | 1 | 32-bit counter selected |
| div_log2 | output | 4 | Prescaler ratio as a power of two |
| sync_sel | output | 2 | Counter reload / prescaler reset policy |
| run_stby | output | 1 | Keep running in standby |
| on_demand | output | 1 | Effective clock-on-demand request policy |
| auto_lock | output | 1 | Lock buffered updates on wrap events |
| dma_oneshot | output | 1 | One-shot request mode |
| cap_en | output | 2 | Per-channel capture enable |
| cap_pin | output | 2 | Per-channel capture source (1 = pin) |
| cap_mode | output | 4 | Capture kind, channel 1 in bits 3:2 |
| dbg_run | output | 1 | Debug-control bit |

## Verification
The bench attacks the write that sets the reset bit together with every other bit. A design that let the other bits through would read back a non-zero word after the reset. The bench also checks the exact length of both busy windows, so a counter one cycle off shows up as a busy flag seen at the wrong sample. A write placed on the cycle right after an enable change probes the gate. A design that judged protection on the new enable value, or ignored `en_busy`, would take the fields or flip the enable back. A debug write during the reset window, followed by a readback, shows both a leaky bus shut-out and a reset that wrongly clears the debug register.

// File: rtl/timer_ctrl_reg.sv
`timescale 1ns/1ps
module timer_ctrl_reg #(
  parameter int AW       = 4,
  parameter int SYNC_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          standby,
  output logic          en_active,
  output logic          en_busy,
  output logic          rst_busy,
  output logic          cnt_8b,
  output logic          cnt_16b,
  output logic          cnt_32b,
  output logic [3:0]    div_log2,
  output logic [1:0]    sync_sel,
  output logic          run_stby,
  output logic          on_demand,
  output logic          auto_lock,
  output logic          dma_oneshot,
  output logic [1:0]    cap_en,
  output logic [1:0]    cap_pin,
  output logic [3:0]    cap_mode,
  output logic          dbg_run
);
  localparam int CW = $clog2(SYNC_LAT + 1);
  localparam logic [AW-1:0] CTL_ADDR = AW'(0);
  localparam logic [AW-1:0] DBG_ADDR = AW'(1);

  logic [20:2]   cfg_q;
  logic          en_q;
  logic          act_q;
  logic          dbg_q;
  logic [CW-1:0] en_cnt;
  logic [CW-1:0] rst_cnt;

  assign en_busy  = en_cnt != '0;
  assign rst_busy = rst_cnt != '0;

  logic ctl_wr, rst_req, en_wr, cfg_wr, dbg_wr;
  assign ctl_wr  = bus_we && bus_addr == CTL_ADDR && !rst_busy;
  assign rst_req = ctl_wr && bus_wdata[0];
  assign en_wr   = ctl_wr && !bus_wdata[0] && !en_busy && (bus_wdata[1] != en_q);
  assign cfg_wr  = ctl_wr && !bus_wdata[0] && !en_busy && !en_q;
  assign dbg_wr  = bus_we && bus_addr == DBG_ADDR && !rst_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      dbg_q   <= 1'b0;
      en_cnt  <= '0;
      rst_cnt <= '0;
    end else if (rst_req) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      en_cnt  <= '0;
      rst_cnt <= CW'(SYNC_LAT);
    end else begin
      if (rst_busy) begin
        rst_cnt <= rst_cnt - CW'(1);
        if (rst_cnt == CW'(1)) act_q <= 1'b0;
      end
      if (cfg_wr) cfg_q <= bus_wdata[20:2];
      if (en_wr) begin
        en_q   <= bus_wdata[1];
        en_cnt <= CW'(SYNC_LAT);
      end else if (en_busy) begin
        en_cnt <= en_cnt - CW'(1);
        if (en_cnt == CW'(1)) act_q <= en_q;
      end
      if (dbg_wr) dbg_q <= bus_wdata[0];
    end
  end

  assign en_active = act_q;
  assign dbg_run   = dbg_q;

  assign cnt_16b = cfg_q[3:2] == 2'd0;
  assign cnt_8b  = cfg_q[3:2] == 2'd1;
  assign cnt_32b = cfg_q[3:2] == 2'd2;

  always_comb begin
    case (cfg_q[6:4])
      3'd5:    div_log2 = 4'd6;
      3'd6:    div_log2 = 4'd8;
      3'd7:    div_log2 = 4'd10;
      default: div_log2 = {1'b0, cfg_q[6:4]};
    endcase
  end

  assign sync_sel    = cfg_q[8:7];
  assign run_stby    = cfg_q[9];
  assign on_demand   = cfg_q[10] & (cfg_q[9] | ~standby);
  assign auto_lock   = cfg_q[11];
  assign dma_oneshot = cfg_q[12];
  assign cap_en      = cfg_q[14:13];
  assign cap_pin     = cfg_q[16:15];
  assign cap_mode    = cfg_q[20:17];

  always_comb begin
    if (rst_busy)                 bus_rdata = '0;
    else if (bus_addr == CTL_ADDR) bus_rdata = {11'b0, cfg_q, en_q, 1'b0};
    else if (bus_addr == DBG_ADDR) bus_rdata = {31'b0, dbg_q};
    else                          bus_rdata = '0;
  end

  // R1
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_busy && !en_busy);

  // R4
  dbg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> $stable(dbg_q));

  // R5
  act_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $fell(en_busy) || $fell(rst_busy));

  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_busy || en_q) && !rst_req |=> $stable(cfg_q));

  // R8
  width_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_8b, cnt_16b, cnt_32b}));

  // R10
  ondemand_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby && !run_stby |-> !on_demand);
endmodule

// File: tb/timer_ctrl_reg_test.sv
`timescale 1ns/1ps
module timer_ctrl_reg_test;
  localparam int AW = 4;
  localparam int SYNC_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic standby = 1'b0;
  logic en_active, en_busy, rst_busy, cnt_8b, cnt_16b, cnt_32b;
  logic [3:0] div_log2;
  logic [1:0] sync_sel, cap_en, cap_pin;
  logic run_stby, on_demand, auto_lock, dma_oneshot, dbg_run;
  logic [3:0] cap_mode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  timer_ctrl_reg #(.AW(AW), .SYNC_LAT(SYNC_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .standby(standby),
    .en_active(en_active), .en_busy(en_busy), .rst_busy(rst_busy),
    .cnt_8b(cnt_8b), .cnt_16b(cnt_16b), .cnt_32b(cnt_32b),
    .div_log2(div_log2), .sync_sel(sync_sel), .run_stby(run_stby),
    .on_demand(on_demand), .auto_lock(auto_lock), .dma_oneshot(dma_oneshot),
    .cap_en(cap_en), .cap_pin(cap_pin), .cap_mode(cap_mode), .dbg_run(dbg_run)
  );

  // {write data, expected readback, expected div_log2, expected {32b,16b,8b}}
  localparam logic [70:0] VEC [0:9] = '{
    {32'h0000_0004, 32'h0000_0004, 4'd0,  3'b001},
    {32'h0000_0038, 32'h0000_0038, 4'd3,  3'b100},
    {32'h001F_FFFC, 32'h001F_FFFC, 4'd10, 3'b000},
    {32'h0000_0002, 32'h0000_0002, 4'd0,  3'b010},
    {32'h0000_07F2, 32'h0000_0002, 4'd0,  3'b010},
    {32'h0000_0000, 32'h0000_0000, 4'd0,  3'b010},
    {32'h0000_0050, 32'h0000_0050, 4'd6,  3'b010},
    {32'h0000_0060, 32'h0000_0060, 4'd8,  3'b010},
    {32'h0000_0010, 32'h0000_0010, 4'd1,  3'b010},
    {32'h0000_0040, 32'h0000_0040, 4'd4,  3'b010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (SYNC_LAT + 1) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(0, v); check("R11 ctl", v, 32'h0);
    rd(1, v); check("R11 dbg", v, 32'h0);
    check("R11 flags", {29'b0, en_active, en_busy, rst_busy}, 32'h0);

    // R7 R8 R9 vector walk
    for (int i = 0; i < 10; i++) begin
      wr(0, VEC[i][70:39]);
      settle();
      rd(0, v); check("R7 readback", v, VEC[i][38:7]);
      check("R9 div", {28'b0, div_log2}, {28'b0, VEC[i][6:3]});
      check("R8 width", {29'b0, cnt_32b, cnt_16b, cnt_8b}, {29'b0, VEC[i][2:0]});
    end
    wr(0, 32'h0); settle();

    // R5 enable latency
    wr(0, 32'h2);
    check("R5 busy0", {31'b0, en_busy}, 32'h1);
    check("R5 act0", {31'b0, en_active}, 32'h0);
    @(negedge clk);
    check("R5 busy1", {31'b0, en_busy}, 32'h1);
    @(negedge clk);
    check("R5 busy2", {31'b0, en_busy}, 32'h1);
    check("R5 act2", {31'b0, en_active}, 32'h0);
    @(negedge clk);
    check("R5 busy3", {31'b0, en_busy}, 32'h0);
    check("R5 act3", {31'b0, en_active}, 32'h1);
    wr(0, 32'h2);
    check("R5 same value", {31'b0, en_busy}, 32'h0);

    // R6 R7 write on the cycle after an enable change
    wr(0, 32'h0);
    wr(0, 32'h6);
    settle();
    check("R6 enable kept", {31'b0, en_active}, 32'h0);
    rd(0, v); check("R7 busy drop", v, 32'h0);
    wr(0, 32'h4); settle();
    rd(0, v); check("R7 accepted", v, 32'h4);

    // R10 on-demand forcing
    wr(0, 32'h400); settle();
    standby = 1'b0; #1 check("R10 awake", {31'b0, on_demand}, 32'h1);
    standby = 1'b1; #1 check("R10 forced", {31'b0, on_demand}, 32'h0);
    @(negedge clk);
    wr(0, 32'h600); settle();
    check("R10 run stby", {31'b0, on_demand}, 32'h1);
    standby = 1'b0;

    // R3 zero in reset bit
    wr(0, 32'h4);
    check("R3 no reset", {31'b0, rst_busy}, 32'h0);
    settle();
    rd(0, v); check("R3 readback", v, 32'h4);

    // R1 R2 R4 software reset
    wr(1, 32'h1);
    wr(0, 32'h7FC); settle();
    wr(0, 32'h2); settle();
    check("R1 pre enabled", {31'b0, en_active}, 32'h1);
    wr(0, 32'hFFFF_FFFF);
    check("R1 busy0", {31'b0, rst_busy}, 32'h1);
    rd(1, v); check("R4 read zero", v, 32'h0);
    wr(1, 32'h0);
    check("R1 busy1", {31'b0, rst_busy}, 32'h1);
    wr(0, 32'h4);
    check("R1 busy2", {31'b0, rst_busy}, 32'h1);
    @(negedge clk);
    check("R1 busy3", {31'b0, rst_busy}, 32'h0);
    check("R1 disabled", {31'b0, en_active}, 32'h0);
    rd(0, v); check("R1 cleared", v, 32'h0);
    check("R4 ctl ignored", {28'b0, div_log2}, 32'h0);
    rd(1, v); check("R2 dbg kept", v, 32'h1);
    check("R2 dbg out", {31'b0, dbg_run}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule